// File: doc/BRIEF.md
# Victim Buffer

This block sits next to a direct-mapped primary cache. Several line addresses share each slot of that cache, so a line that was just thrown out is often needed again soon. The buffer catches every line the primary cache discards and keeps a handful of them in a small fully associative store. When the primary cache misses, it probes the buffer first. A buffer hit returns the line in the same cycle, so no next-level access is needed. In effect, the sets that conflict most gain a few extra ways.

A hit moves the line back into the primary cache and frees its buffer entry. If the primary cache discards the line it is overwriting in that same cycle, the two lines change places. The buffer count stays the same and the incoming line becomes the newest entry. When the buffer is full, a new discard pushes out the oldest entry. When a probe misses in the buffer, the block raises a request to the next level and holds it until a fill handshake arrives. No further probes are taken while that request is open.

Top module: `victim_buffer`

## Requirements
- R1: After a synchronous reset, the buffer holds no lines: every probe misses, `lookup_ready` is 1 and `mem_req_valid` is 0.
- R2: A line presented on the eviction port is stored. A later probe with the same full line address reports `lookup_hit` = 1 in the same cycle, with the stored data on `lookup_data`.
- R3: A probe that hits removes the line from the buffer, so a second probe of that address misses.
- R4: The buffer holds `ENTRIES` lines. An eviction into a full buffer discards the oldest line by insertion order, and all other lines stay.
- R5: A hit and an eviction in the same cycle act as a swap. The hitting line is returned, the evicted line is stored as the newest entry, and no other line is lost.
- R6: A probe that misses while `lookup_ready` is 1 raises `mem_req_valid` on the next cycle, with the probed address on `mem_req_addr`. Both hold steady until a cycle with `fill_valid` = 1. After that cycle the request drops and `lookup_ready` returns to 1.
- R7: While a request is open, `lookup_ready` is 0. A probe made then gets no hit, removes no line and starts no new request.
- R8: Evictions are accepted and stored while a request is open.
- R9: Removing a line from the middle of the buffer keeps the age order of the other lines. The next overflow after that removal discards the oldest remaining line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evict_valid | input | 1 | Primary cache is discarding a line this cycle |
| evict_addr | input | ADDR_W | Line address of the discarded line |
| evict_data | input | DATA_W | Data of the discarded line |
| lookup_valid | input | 1 | Probe after a primary-cache miss |
| lookup_addr | input | ADDR_W | Line address probed |
| lookup_ready | output | 1 | Probes are accepted (no request open) |
| lookup_hit | output | 1 | Probe found the line in this cycle |
| lookup_data | output | DATA_W | Line data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Request open to the next level |
| mem_req_addr | output | ADDR_W | Line address requested |
| fill_valid | input | 1 | Next level has delivered the requested line |

## Verification
The bench targets three orderings. The first is a swap in a full buffer. A design that appended before freeing the hit entry would drop a live line, and one that freed without appending would lose the evicted one. The second is removal from the middle followed by overflow. A plain write pointer would then overwrite a newer line instead of the oldest survivor. The third is a probe during an open request. A design that did not gate it would remove a line or reissue the request, and a design that blocked evictions while waiting would lose the discard that arrived then.

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              lookup_ready,
  output logic              lookup_hit,
  output logic [DATA_W-1:0] lookup_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              fill_valid
);
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ADDR_W-1:0] tag_q [ENTRIES];
  logic [DATA_W-1:0] dat_q [ENTRIES];
  logic [ADDR_W-1:0] tag_n [ENTRIES];
  logic [DATA_W-1:0] dat_n [ENTRIES];
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]  hit_idx;
  logic              busy_q;
  logic [ADDR_W-1:0] req_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = (g < int'(cnt_q)) && (tag_q[g] == lookup_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign lookup_ready  = !busy_q;
  assign lookup_hit    = lookup_valid && lookup_ready && (|match);
  assign lookup_data   = lookup_hit ? dat_q[hit_idx] : '0;
  assign mem_req_valid = busy_q;
  assign mem_req_addr  = req_q;

  always_comb begin
    tag_n = tag_q;
    dat_n = dat_q;
    cnt_n = cnt_q;
    if (lookup_hit) begin
      for (int i = 0; i < ENTRIES - 1; i++)
        if (i >= int'(hit_idx)) begin
          tag_n[i] = tag_q[i+1];
          dat_n[i] = dat_q[i+1];
        end
      cnt_n = cnt_q - CNT_W'(1);
    end
    if (evict_valid) begin
      if (int'(cnt_n) == ENTRIES) begin
        for (int i = 0; i < ENTRIES - 1; i++) begin
          tag_n[i] = tag_n[i+1];
          dat_n[i] = dat_n[i+1];
        end
        tag_n[ENTRIES-1] = evict_addr;
        dat_n[ENTRIES-1] = evict_data;
      end else begin
        for (int i = 0; i < ENTRIES; i++)
          if (i == int'(cnt_n)) begin
            tag_n[i] = evict_addr;
            dat_n[i] = evict_data;
          end
        cnt_n = cnt_n + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    tag_q <= tag_n;
    dat_q <= dat_n;
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (busy_q) begin
        if (fill_valid) busy_q <= 1'b0;
      end else if (lookup_valid && !(|match)) begin
        busy_q <= 1'b1;
        req_q  <= lookup_addr;
      end
    end
  end

  AST_REQ_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && lookup_ready && !lookup_hit) |=> (mem_req_valid && mem_req_addr == $past(lookup_addr))); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !fill_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R6
  AST_BUSY_PROBE_INERT: assert property (@(posedge clk) disable iff (rst)
    (!lookup_ready && !evict_valid) |=> $stable(cnt_q)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= ENTRIES); // R4
  AST_SWAP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (lookup_hit && evict_valid) |=> (cnt_q == $past(cnt_q))); // R5
  AST_EVICT_GROWS: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && !lookup_hit && int'(cnt_q) < ENTRIES) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_HIT_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (lookup_hit && !evict_valid) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R2
endmodule

// File: tb/tb_victim_buffer.sv
`timescale 1ns/1ps
module tb_victim_buffer;
  localparam int AW = 26;
  localparam int DW = 64;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evict_valid = 1'b0, lookup_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0, lookup_addr = '0;
  logic [DW-1:0] evict_data = '0;
  logic lookup_ready, lookup_hit, mem_req_valid;
  logic [DW-1:0] lookup_data;
  logic [AW-1:0] mem_req_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  victim_buffer #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(N)) dut (
    .clk(clk), .rst(rst),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .lookup_ready(lookup_ready), .lookup_hit(lookup_hit), .lookup_data(lookup_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .fill_valid(fill_valid));

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
    return {32'hC0DE0000 ^ 32'(a), 32'(a) * 32'h9E3779B9};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic evict(input logic [AW-1:0] a);
    @(negedge clk);
    evict_valid = 1'b1; evict_addr = a; evict_data = dat(a);
    @(posedge clk); #1;
    evict_valid = 1'b0;
  endtask

  task automatic service_miss(input string req, input logic [AW-1:0] a);
    @(negedge clk);
    chk(req, DW'(mem_req_valid), 1);
    chk(req, DW'(mem_req_addr), DW'(a));
    chk(req, DW'(lookup_ready), 0);
    fill_valid = 1'b1;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk);
    chk(req, DW'(mem_req_valid), 0);
    chk(req, DW'(lookup_ready), 1);
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input bit exp_hit);
    logic got;
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = a;
    #1;
    got = lookup_hit;
    chk(req, DW'(got), DW'(exp_hit));
    if (exp_hit && got) chk(req, lookup_data, dat(a));
    @(posedge clk); #1;
    lookup_valid = 1'b0;
    if (!got) service_miss(req, a);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", DW'(lookup_ready), 1);
    chk("R1", DW'(mem_req_valid), 0);
    probe("R1", 26'h0000100, 1'b0);
  endtask

  task automatic t_capture_remove;
    evict(26'h0000A11);
    probe("R2", 26'h0000A11, 1'b1);
    probe("R3", 26'h0000A11, 1'b0);
  endtask

  task automatic t_fifo;
    for (int i = 0; i <= N; i++) evict(AW'(26'h0100 + i));
    probe("R4", 26'h0100, 1'b0);
    for (int i = 1; i <= N; i++) probe("R4", AW'(26'h0100 + i), 1'b1);
  endtask

  task automatic t_swap;
    for (int i = 0; i < N; i++) evict(AW'(26'h0200 + i));
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = 26'h0201;
    evict_valid = 1'b1; evict_addr = 26'h02F0; evict_data = dat(26'h02F0);
    #1;
    chk("R5", DW'(lookup_hit), 1);
    chk("R5", lookup_data, dat(26'h0201));
    @(posedge clk); #1;
    lookup_valid = 1'b0; evict_valid = 1'b0;
    evict(26'h02F1);
    probe("R5", 26'h0200, 1'b0);
    probe("R5", 26'h0202, 1'b1);
    probe("R5", 26'h0203, 1'b1);
    probe("R5", 26'h02F0, 1'b1);
    probe("R5", 26'h02F1, 1'b1);
  endtask

  task automatic t_middle;
    for (int i = 0; i < N; i++) evict(AW'(26'h0300 + i));
    probe("R9", 26'h0301, 1'b1);
    evict(26'h03E0);
    evict(26'h03E1);
    probe("R9", 26'h0300, 1'b0);
    probe("R9", 26'h0302, 1'b1);
    probe("R9", 26'h0303, 1'b1);
    probe("R9", 26'h03E0, 1'b1);
    probe("R9", 26'h03E1, 1'b1);
  endtask

  task automatic t_busy;
    evict(26'h0400);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = 26'h04FF;
    @(posedge clk); #1;
    lookup_valid = 1'b0;
    @(negedge clk);
    chk("R6", DW'(mem_req_valid), 1);
    chk("R6", DW'(mem_req_addr), DW'(26'h04FF));
    lookup_valid = 1'b1; lookup_addr = 26'h0400;
    evict_valid = 1'b1; evict_addr = 26'h0410; evict_data = dat(26'h0410);
    #1;
    chk("R7", DW'(lookup_hit), 0);
    chk("R7", DW'(lookup_ready), 0);
    @(posedge clk); #1;
    lookup_valid = 1'b0; evict_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R6", DW'(mem_req_valid), 1);
      chk("R7", DW'(mem_req_addr), DW'(26'h04FF));
    end
    service_miss("R6", 26'h04FF);
    probe("R7", 26'h0400, 1'b1);
    probe("R8", 26'h0410, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_capture_remove();
    t_fifo();
    t_swap();
    t_middle();
    t_busy();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule